// File: doc/BRIEF.md
# FIFO Trigger Level Selector

This block decides when a UART's receive FIFO holds enough characters, and when its transmit FIFO has enough free room, to raise a service request. Interrupt and DMA logic use these requests. It holds one 8-bit trigger register made of two 4-bit fields, one for each direction. A nonzero field sets a level in steps of four entries. A zero field hands that direction back to a coarse level, which a 2-bit code from the FIFO control register selects.

The receive request compares the number of characters waiting against the effective receive level. The transmit request compares the free space, which is the depth minus the occupancy, against the effective transmit level. Both requests are combinational in the counts, the select codes and the stored register. A register write takes effect from the clock edge that captures it. Writes land only while two enable inputs are both high.

Top module: `fifo_trig_sel`

## Requirements
- R1: After reset the trigger register is zero, so both directions use their fallback levels.
- R2: A write with `wr_en` high changes the register only when `feat_en` and `mode_en` are both 1. Otherwise the register keeps its value.
- R3: Register bits [7:4] are the receive field and bits [3:0] are the transmit field. A nonzero field value F gives a level of 4*F entries, from 4 to 60.
- R4: When the receive field is 0, the receive level follows `rx_sel`: code 0 gives 8, code 1 gives 16, code 2 gives 56 and code 3 gives 60 characters.
- R5: When the transmit field is 0, the transmit level follows `tx_sel`: code 0 gives 8, code 1 gives 16, code 2 gives 32 and code 3 gives 56 spaces.
- R6: `rx_ready` is 1 exactly when `rx_count` is greater than or equal to the effective receive level.
- R7: `tx_ready` is 1 exactly when 64 minus `tx_count` is greater than or equal to the effective transmit level.
- R8: The two fields are independent. A zero field in one direction with a nonzero field in the other uses the fallback for the zero field only.
- R9: Changes on the counts and select codes reach the requests in the same cycle. A register write reaches them only after the capturing clock edge.

Top module ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Trigger register write strobe |
| wr_data | input | 8 | Write data: receive field [7:4], transmit field [3:0] |
| feat_en | input | 1 | Enhanced-feature enable; must be 1 for a write |
| mode_en | input | 1 | Mode-control enable; must be 1 for a write |
| rx_sel | input | 2 | Coarse receive level code from the FIFO control register |
| tx_sel | input | 2 | Coarse transmit level code from the FIFO control register |
| rx_count | input | 7 | Characters held in the receive FIFO (0 to 64) |
| tx_count | input | 7 | Entries held in the transmit FIFO (0 to 64) |
| rx_ready | output | 1 | Receive service request |
| tx_ready | output | 1 | Transmit service request |

## Verification
The bench sweeps the counts across each level at the level minus one, the level itself and the level plus one. A design that compares with "greater than", or that counts occupancy where it should count free space, gives a request one entry late or in the wrong direction. It writes with each enable low by itself, so a design that gates on only one enable picks up a field it should reject. It programs one field at zero and the other nonzero, so a design that falls back only when the whole register is zero uses the wrong receive or transmit level. It also looks at the outputs between a write strobe and its capturing edge, which shows any write path that goes around the register.

// File: rtl/fts_pkg.sv
package fts_pkg;

  typedef struct packed {
    logic [3:0] rx;
    logic [3:0] tx;
  } trig_fields_t;

  function automatic int unsigned rx_fallback(input logic [1:0] code,
                                              input int unsigned depth);
    case (code)
      2'd0:    return depth / 8;
      2'd1:    return depth / 4;
      2'd2:    return depth - 8;
      default: return depth - 4;
    endcase
  endfunction

  function automatic int unsigned tx_fallback(input logic [1:0] code,
                                              input int unsigned depth);
    case (code)
      2'd0:    return depth / 8;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 8;
    endcase
  endfunction

endpackage

// File: rtl/fts_rst_sync.sv
module fts_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/fts_trig_reg.sv
module fts_trig_reg
  import fts_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rst_n_sync,
  input  logic         wr_en,
  input  logic [7:0]   wr_data,
  input  logic         feat_en,
  input  logic         mode_en,
  output trig_fields_t fields
);
  trig_fields_t reg_q, reg_d;
  logic         load_en;

  always_comb begin
    load_en = wr_en & feat_en & mode_en;
    reg_d   = reg_q;
    if (load_en) reg_d = trig_fields_t'(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) reg_q <= '0;
    else             reg_q <= reg_d;
  end

  assign fields = reg_q;

  // R2: blocked writes leave the register alone
  p_wr_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !(wr_en && feat_en && mode_en) |=> $stable(fields));

  // R3: accepted write lands with receive field in the upper nibble
  p_wr_load_r3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wr_en && feat_en && mode_en) |=> (fields.rx == $past(wr_data[7:4]) &&
                                       fields.tx == $past(wr_data[3:0])));

  // R1: while the raw reset is low the register is clear
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (fields == '0));
endmodule

// File: rtl/fts_level_sel.sv
module fts_level_sel
  import fts_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int STEP    = 4,
  parameter int FIELD_W = 4,
  parameter bit IS_RX   = 1'b1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] field,
  input  logic [1:0]         sel,
  output logic [CNT_W-1:0]   level
);
  localparam logic [CNT_W-1:0] STEP_C = CNT_W'(STEP);
  logic [CNT_W-1:0] coarse;
  logic [CNT_W-1:0] fine;

  generate
    if (IS_RX) begin : g_rx
      always_comb coarse = CNT_W'(rx_fallback(sel, DEPTH));
    end else begin : g_tx
      always_comb coarse = CNT_W'(tx_fallback(sel, DEPTH));
    end
  endgenerate

  always_comb begin
    fine  = CNT_W'(field) * STEP_C;
    level = (field != '0) ? fine : coarse;
  end

  // R3: the effective level is a nonzero multiple of the step inside the FIFO
  p_level_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (level >= STEP_C) && (level < CNT_W'(DEPTH)) && ((level % STEP_C) == 0));

  // R8: holding the field and code keeps the level steady
  p_level_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(field) && $stable(sel)) |-> $stable(level));
endmodule

// File: rtl/fts_thresh_cmp.sv
module fts_thresh_cmp #(
  parameter int DEPTH  = 64,
  parameter bit IS_RX  = 1'b1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] level,
  output logic             ready
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  logic [CNT_W-1:0] avail;

  generate
    if (IS_RX) begin : g_chars
      always_comb avail = count;
    end else begin : g_space
      always_comb avail = DEPTH_C - count;
    end
  endgenerate

  always_comb ready = (avail >= level);

  // R6/R7: counts stay inside the FIFO depth
  p_count_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C);

  // R6/R7: with the level fixed, more available entries never drop the request
  p_ready_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ready) && $stable(level) && (avail >= $past(avail))) |-> ready);
endmodule

// File: rtl/fifo_trig_sel.sv
module fifo_trig_sel
  import fts_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int STEP    = 4,
  parameter int FIELD_W = 4,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             feat_en,
  input  logic             mode_en,
  input  logic [1:0]       rx_sel,
  input  logic [1:0]       tx_sel,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  output logic             rx_ready,
  output logic             tx_ready
);
  logic             rst_n_sync;
  trig_fields_t     fields;
  logic [CNT_W-1:0] rx_level;
  logic [CNT_W-1:0] tx_level;

  fts_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  fts_trig_reg u_reg (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync),
    .wr_en(wr_en), .wr_data(wr_data),
    .feat_en(feat_en), .mode_en(mode_en), .fields(fields)
  );

  fts_level_sel #(.DEPTH(DEPTH), .STEP(STEP), .FIELD_W(FIELD_W), .IS_RX(1'b1)) u_rx_lvl (
    .clk(clk), .rst_n(rst_n_sync), .field(fields.rx), .sel(rx_sel), .level(rx_level)
  );

  fts_level_sel #(.DEPTH(DEPTH), .STEP(STEP), .FIELD_W(FIELD_W), .IS_RX(1'b0)) u_tx_lvl (
    .clk(clk), .rst_n(rst_n_sync), .field(fields.tx), .sel(tx_sel), .level(tx_level)
  );

  fts_thresh_cmp #(.DEPTH(DEPTH), .IS_RX(1'b1)) u_rx_cmp (
    .clk(clk), .rst_n(rst_n_sync), .count(rx_count), .level(rx_level), .ready(rx_ready)
  );

  fts_thresh_cmp #(.DEPTH(DEPTH), .IS_RX(1'b0)) u_tx_cmp (
    .clk(clk), .rst_n(rst_n_sync), .count(tx_count), .level(tx_level), .ready(tx_ready)
  );

  // R9: with no write, a steady input set gives steady requests
  p_no_write_steady_r9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!$past(wr_en) && $stable(rx_count) && $stable(tx_count) &&
     $stable(rx_sel) && $stable(tx_sel)) |-> ($stable(rx_ready) && $stable(tx_ready)));
endmodule

// File: tb/fifo_trig_sel_tb_top.sv
module fifo_trig_sel_tb_top;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, feat_en, mode_en;
  logic [7:0] wr_data;
  logic [1:0] rx_sel, tx_sel;
  logic [6:0] rx_count, tx_count;
  logic       rx_ready, tx_ready;

  int checks = 0;
  int errors = 0;
  logic [7:0] model_reg;

  always #(PERIOD/2) clk = ~clk;

  fifo_trig_sel dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .feat_en(feat_en), .mode_en(mode_en), .rx_sel(rx_sel), .tx_sel(tx_sel),
    .rx_count(rx_count), .tx_count(tx_count), .rx_ready(rx_ready), .tx_ready(tx_ready)
  );

  function automatic int rx_lvl(input logic [7:0] r, input logic [1:0] s);
    if (r[7:4] != 0) return 4 * r[7:4];
    case (s) 0: return 8; 1: return 16; 2: return 56; default: return 60; endcase
  endfunction

  function automatic int tx_lvl(input logic [7:0] r, input logic [1:0] s);
    if (r[3:0] != 0) return 4 * r[3:0];
    case (s) 0: return 8; 1: return 16; 2: return 32; default: return 56; endcase
  endfunction

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b (reg=%h rxc=%0d txc=%0d rs=%0d ts=%0d)",
               req, act, exp, model_reg, rx_count, tx_count, rx_sel, tx_sel);
    end
  endtask

  task automatic check_both(input string req);
    #1;
    check_bit(req, rx_ready, (int'(rx_count) >= rx_lvl(model_reg, rx_sel)));
    check_bit(req, tx_ready, ((DEPTH - int'(tx_count)) >= tx_lvl(model_reg, tx_sel)));
  endtask

  task automatic do_write(input logic [7:0] d, input logic f, input logic m);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; feat_en = f; mode_en = m;
    @(negedge clk);
    wr_en = 1'b0; feat_en = 1'b0; mode_en = 1'b0;
    if (f && m) model_reg = d;
  endtask

  task automatic sweep(input string req);
    for (int c = 0; c <= DEPTH; c++) begin
      @(negedge clk);
      rx_count = 7'(c); tx_count = 7'(DEPTH - c);
      check_both(req);
    end
  endtask

  task automatic t_reset;
    rx_count = 7'd8; tx_count = 7'd56;
    @(negedge clk); check_both("R1 during reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_both("R1 after reset");
    rx_count = 7'd7; tx_count = 7'd57;
    check_both("R1 fallback below level");
  endtask

  task automatic t_rx_fallback;
    for (int s = 0; s < 4; s++) begin
      rx_sel = 2'(s);
      sweep("R4 R6 rx fallback");
    end
  endtask

  task automatic t_tx_fallback;
    for (int s = 0; s < 4; s++) begin
      tx_sel = 2'(s);
      sweep("R5 R7 tx fallback");
    end
  endtask

  task automatic t_gate;
    rx_sel = 2'd0; tx_sel = 2'd0;
    do_write(8'h11, 1'b1, 1'b0);
    @(negedge clk); rx_count = 7'd4; tx_count = 7'd60; check_both("R2 feat only");
    do_write(8'h11, 1'b0, 1'b1);
    @(negedge clk); check_both("R2 mode only");
    do_write(8'h11, 1'b0, 1'b0);
    @(negedge clk); check_both("R2 neither");
    check_bit("R2 rx unchanged", rx_ready, 1'b0);
  endtask

  task automatic t_program;
    do_write(8'h3F, 1'b1, 1'b1);
    sweep("R3 R6 R7 fields 3/15");
    do_write(8'hF1, 1'b1, 1'b1);
    sweep("R3 fields 15/1");
    do_write(8'h9A, 1'b1, 1'b1);
    sweep("R3 fields 9/10");
  endtask

  task automatic t_indep;
    rx_sel = 2'd2; tx_sel = 2'd3;
    do_write(8'h05, 1'b1, 1'b1);
    sweep("R8 rx zero tx set");
    do_write(8'h70, 1'b1, 1'b1);
    sweep("R8 rx set tx zero");
  endtask

  task automatic t_timing;
    do_write(8'h00, 1'b1, 1'b1);
    rx_sel = 2'd0; tx_sel = 2'd0;
    @(negedge clk);
    rx_count = 7'd4; tx_count = 7'd60;
    check_both("R9 before write");
    wr_en = 1'b1; wr_data = 8'h11; feat_en = 1'b1; mode_en = 1'b1;
    #1;
    check_bit("R9 no early rx", rx_ready, 1'b0);
    check_bit("R9 no early tx", tx_ready, 1'b0);
    @(negedge clk);
    wr_en = 1'b0; feat_en = 1'b0; mode_en = 1'b0; model_reg = 8'h11;
    check_both("R9 after edge");
    check_bit("R9 rx now set", rx_ready, 1'b1);
    rx_count = 7'd3;
    check_both("R9 same-cycle count");
    rx_sel = 2'd3;
    do_write(8'h0F, 1'b1, 1'b1);
    @(negedge clk); rx_count = 7'd60; check_both("R9 sel same cycle");
    rx_sel = 2'd2; check_both("R9 sel change");
  endtask

  initial begin : watchdog
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; feat_en = 1'b0; mode_en = 1'b0;
    rx_sel = 2'd0; tx_sel = 2'd0; model_reg = 8'h00;
    t_reset();
    t_rx_fallback();
    t_tx_fallback();
    t_gate();
    t_program();
    t_indep();
    t_timing();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule